// File: doc/BRIEF.md
# Polynomial Fetch Address Sequencer

This block produces the instruction fetch address of a small 4-bit controller whose program counter does not count in binary. The 11-bit address is split into a 6-bit page-position field, which steps through a shift-register sequence with feedback, and a 5-bit bank field above it. The bank field is a counter: each time the page-position field runs through its full cycle and returns to zero, the bank advances by one. A program that never branches therefore walks all 2048 program words before it comes back to where it started.

The core drives `step_i` once per machine cycle. A direct transfer takes two machine cycles. The cycle that issues it also fetches its operand word, and the following cycle loads the target. A table jump takes effect later still: the two words after it are fetched and executed in order, and only the step after those loads the computed target. Both kinds of redirect replace the bank field and the page-position field together, and sequencing continues from the target.

After reset the fetch address is 03C0h. The first four steps are pipeline fill, during which the address is marked not valid. This matches a stream in which the fifth word read out is the word at 03C0h.

Top module: `seqpc_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `fetch_addr_o` is 03C0h and both `fetch_vld_o` and `wrap_o` are 0.
- R2: The first four steps after reset hold the address at 03C0h with `fetch_vld_o` low. Transfer and table-jump requests made during these steps have no effect. `fetch_vld_o` goes to 1 after the fourth step and stays at 1 until the next reset.
- R3: In a cycle where `step_i` is low, the address, the pending redirect and the target do not change, and `wrap_o` is 0 in the following cycle.
- R4: A sequential step replaces page-position field p (address bits 5:0) with {p[4:0], p[5] ^ p[4] ^ (p[4:0] == 0)}. This is a 64-state cycle through every 6-bit code: 100000 goes to 000000, and 000000 goes to 000001.
- R5: The bank field (address bits 10:6) increments on exactly those sequential steps that move the page-position field from 100000 to 000000. Bank 31 wraps to 0.
- R6: `wrap_o` is 1 for exactly the one clock that follows a bank-incrementing step, and is 0 at all other times.
- R7: Starting from 03C0h with valid fetch, 2048 consecutive plain steps present every 11-bit address exactly once, and the next step returns to 03C0h.
- R8: A step with `xfer_i` high and nothing pending moves to the sequential successor (the operand word). The next step loads `xfer_tgt_i`, as captured at the issuing step, into both fields.
- R9: A step with `tjmp_i` high (and `xfer_i` low) and nothing pending is followed by two sequential successors. The third step loads `tjmp_tgt_i`, as captured at the issuing step.
- R10: While a redirect is pending, `xfer_i` and `tjmp_i` are ignored. When both are high on an issuing step, the transfer wins.
- R11: After a redirect loads a target, plain steps continue the sequence of R4 and R5 from that target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance one machine cycle |
| xfer_i | input | 1 | Issue a direct transfer on this step |
| xfer_tgt_i | input | 11 | Direct transfer target address |
| tjmp_i | input | 1 | Issue a table jump on this step |
| tjmp_tgt_i | input | 11 | Computed table-jump target address |
| fetch_addr_o | output | 11 | Current fetch address {bank, page position} |
| fetch_vld_o | output | 1 | Fetch address valid (pipeline fill finished) |
| wrap_o | output | 1 | One-clock pulse after a bank increment |

## Verification
The main check is an unbroken run of 2048 plain steps from 03C0h. Only a correct 64-state feedback rule, together with bank carries at the right moment, visits each address exactly once, and this run also crosses the bank 31 to 0 wrap. Direct transfers and table jumps are issued with gaps in `step_i`, with competing requests while they are pending, and with both requests at once. This separates the one-step and two-step redirect delays and shows whether the target is captured at issue or sampled late. A transfer to bank 31, page position 100000, checks that the carry follows a redirect. Requests made during pipeline fill show whether the fill steps ignore them.

// File: rtl/seqpc_pkg.sv
package seqpc_pkg;
  localparam int unsigned POLY_W     = 6;
  localparam int unsigned BANK_W     = 5;
  localparam int unsigned ADDR_W     = POLY_W + BANK_W;
  localparam logic [POLY_W-1:0] POLY_TAPS = 6'b110000;
  localparam logic [ADDR_W-1:0] RESET_ADDR = 11'h3C0;
  localparam int unsigned FILL_STEPS = 4;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_XFER  = 2'd1,
    PEND_TBL_A = 2'd2,
    PEND_TBL_B = 2'd3
  } pend_e;
endpackage

// File: rtl/seqpc_poly.sv
module seqpc_poly #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] TAPS = 6'b110000,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] poly_o,
  output logic         wrap_next_o
);
  logic [W-1:0] poly_q, poly_d, succ;
  logic         fb;

  // feedback with the zero state spliced into the maximal cycle
  always_comb begin
    fb   = (^(poly_q & TAPS)) ^ (poly_q[W-2:0] == '0);
    succ = {poly_q[W-2:0], fb};
  end

  always_comb begin
    poly_d = poly_q;
    if (load_i)     poly_d = load_val_i;
    else if (adv_i) poly_d = succ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) poly_q <= RST_VAL;
    else if (adv_i || load_i) poly_q <= poly_d;
  end

  assign poly_o      = poly_q;
  assign wrap_next_o = (succ == '0);
endmodule

// File: rtl/seqpc_bank.sv
module seqpc_bank #(
  parameter int unsigned W = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] bank_o
);
  logic [W-1:0] bank_q, bank_d;

  always_comb begin
    bank_d = bank_q;
    if (load_i)     bank_d = load_val_i;
    else if (inc_i) bank_d = bank_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_q <= RST_VAL;
    else if (inc_i || load_i) bank_q <= bank_d;
  end

  assign bank_o = bank_q;
endmodule

// File: rtl/seqpc_ctrl.sv
module seqpc_ctrl
  import seqpc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned FILL = FILL_STEPS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          xfer_i,
  input  logic [AW-1:0] xfer_tgt_i,
  input  logic          tjmp_i,
  input  logic [AW-1:0] tjmp_tgt_i,
  input  logic          poly_wrap_i,
  output logic          adv_o,
  output logic          load_o,
  output logic [AW-1:0] tgt_o,
  output logic          vld_o,
  output logic          wrap_o
);
  pend_e         pend_q, pend_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic          wrap_q, wrap_d;
  logic          run;
  logic          fill_adv;

  generate
    if (FILL > 0) begin : g_fill
      localparam int unsigned FW = $clog2(FILL + 1);
      logic [FW-1:0] fill_q, fill_d;
      always_comb begin
        fill_d = fill_q;
        if (fill_adv) fill_d = fill_q + 1'b1;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fill_q <= '0;
        else if (fill_adv) fill_q <= fill_d;
      end
      assign run = (fill_q == FW'(FILL));
    end else begin : g_nofill
      assign run = 1'b1;
    end
  endgenerate

  assign fill_adv = step_i && !run;

  always_comb begin
    pend_d = pend_q;
    tgt_d  = tgt_q;
    adv_o  = 1'b0;
    load_o = 1'b0;
    if (step_i && run) begin
      unique case (pend_q)
        PEND_NONE: begin
          adv_o = 1'b1;
          if (xfer_i) begin
            pend_d = PEND_XFER;
            tgt_d  = xfer_tgt_i;
          end else if (tjmp_i) begin
            pend_d = PEND_TBL_A;
            tgt_d  = tjmp_tgt_i;
          end
        end
        PEND_XFER: begin
          load_o = 1'b1;
          pend_d = PEND_NONE;
        end
        PEND_TBL_A: begin
          adv_o  = 1'b1;
          pend_d = PEND_TBL_B;
        end
        PEND_TBL_B: begin
          load_o = 1'b1;
          pend_d = PEND_NONE;
        end
        default: pend_d = PEND_NONE;
      endcase
    end
    wrap_d = adv_o && poly_wrap_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= PEND_NONE;
      tgt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= wrap_d;
      if (step_i && run) begin
        pend_q <= pend_d;
        tgt_q  <= tgt_d;
      end
    end
  end

  assign tgt_o  = tgt_q;
  assign vld_o  = run;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/seqpc_seq.sv
module seqpc_seq
  import seqpc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              xfer_i,
  input  logic [ADDR_W-1:0] xfer_tgt_i,
  input  logic              tjmp_i,
  input  logic [ADDR_W-1:0] tjmp_tgt_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              fetch_vld_o,
  output logic              wrap_o
);
  logic              adv, load, poly_wrap;
  logic [ADDR_W-1:0] tgt;
  logic [POLY_W-1:0] poly;
  logic [BANK_W-1:0] bank;

  seqpc_ctrl #(.AW(ADDR_W), .FILL(FILL_STEPS)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step_i),
    .xfer_i      (xfer_i),
    .xfer_tgt_i  (xfer_tgt_i),
    .tjmp_i      (tjmp_i),
    .tjmp_tgt_i  (tjmp_tgt_i),
    .poly_wrap_i (poly_wrap),
    .adv_o       (adv),
    .load_o      (load),
    .tgt_o       (tgt),
    .vld_o       (fetch_vld_o),
    .wrap_o      (wrap_o)
  );

  seqpc_poly #(.W(POLY_W), .TAPS(POLY_TAPS), .RST_VAL(RESET_ADDR[POLY_W-1:0])) i_poly (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (adv),
    .load_i      (load),
    .load_val_i  (tgt[POLY_W-1:0]),
    .poly_o      (poly),
    .wrap_next_o (poly_wrap)
  );

  seqpc_bank #(.W(BANK_W), .RST_VAL(RESET_ADDR[ADDR_W-1:POLY_W])) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (adv && poly_wrap),
    .load_i     (load),
    .load_val_i (tgt[ADDR_W-1:POLY_W]),
    .bank_o     (bank)
  );

  assign fetch_addr_o = {bank, poly};
endmodule

// File: rtl/seqpc_seq_chk.sv
module seqpc_seq_chk
  import seqpc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              step_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              fetch_vld_o,
  input logic              wrap_o
);
  // R2: address parked at the reset value during fill
  a_r2_fill_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_vld_o |-> fetch_addr_o == RESET_ADDR);

  // R2: valid stays high once reached
  a_r2_vld_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_vld_o |=> fetch_vld_o);

  // R3: no step, no movement
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(fetch_addr_o));

  // R3: no step, no wrap pulse
  a_r3_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> !wrap_o);

  // R5: wrap coincides with page position back at zero
  a_r5_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> fetch_addr_o[POLY_W-1:0] == '0);

  // R5: wrap means the bank moved up by one
  a_r5_bank_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wrap_o) |-> fetch_addr_o[ADDR_W-1:POLY_W] ==
                      BANK_W'($past(fetch_addr_o[ADDR_W-1:POLY_W]) + 1'b1));

  // R6: single-clock pulse
  a_r6_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o);
endmodule

bind seqpc_seq seqpc_seq_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .step_i       (step_i),
  .fetch_addr_o (fetch_addr_o),
  .fetch_vld_o  (fetch_vld_o),
  .wrap_o       (wrap_o)
);

// File: tb/test_seqpc_seq.sv
`timescale 1ns/1ps
module test_seqpc_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_i = 1'b0;
  logic        xfer_i = 1'b0;
  logic [10:0] xfer_tgt_i = '0;
  logic        tjmp_i = 1'b0;
  logic [10:0] tjmp_tgt_i = '0;
  logic [10:0] fetch_addr_o;
  logic        fetch_vld_o;
  logic        wrap_o;

  always #2 clk_i = ~clk_i;

  seqpc_seq i_seqpc_seq (.*);

  typedef struct {
    logic [10:0] addr;
    logic        vld;
    logic        wrap;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 0;
  logic [10:0] last_addr;

  // reference model state
  logic [5:0]  m_poly = 6'h00;
  logic [4:0]  m_bank = 5'h0F;
  int          m_fill = 0;
  int          m_pend = 0;
  logic [10:0] m_tgt = '0;

  function automatic logic [5:0] b_next(input logic [5:0] p);
    logic fb;
    fb = p[5] ^ p[4] ^ (p[4:0] == 5'd0);
    return {p[4:0], fb};
  endfunction

  task automatic cycle(input bit st, input bit xf, input logic [10:0] xt,
                       input bit tj, input logic [10:0] tt, input string tag);
    exp_t e;
    bit   adv = 0;
    @(negedge clk_i);
    last_addr  = fetch_addr_o;
    step_i     = st;
    xfer_i     = xf;
    xfer_tgt_i = xt;
    tjmp_i     = tj;
    tjmp_tgt_i = tt;
    e.wrap = 1'b0;
    if (st) begin
      if (m_fill < 4) m_fill++;
      else begin
        case (m_pend)
          0: begin
            adv = 1;
            if (xf) begin m_pend = 1; m_tgt = xt; end
            else if (tj) begin m_pend = 2; m_tgt = tt; end
          end
          1: begin {m_bank, m_poly} = m_tgt; m_pend = 0; end
          2: begin adv = 1; m_pend = 3; end
          default: begin {m_bank, m_poly} = m_tgt; m_pend = 0; end
        endcase
      end
    end
    if (adv) begin
      if (m_poly == 6'b100000) begin
        m_bank = m_bank + 5'd1;
        e.wrap = 1'b1;
      end
      m_poly = b_next(m_poly);
    end
    e.addr = {m_bank, m_poly};
    e.vld  = (m_fill == 4);
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic steps(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(1, 0, '0, 0, '0, tag);
  endtask

  // monitor: compares after each active edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_vec++;
        if (fetch_addr_o !== e.addr || fetch_vld_o !== e.vld || wrap_o !== e.wrap) begin
          n_bad++;
          $display("FAIL %s: addr=%h vld=%b wrap=%b, expected addr=%h vld=%b wrap=%b",
                   e.tag, fetch_addr_o, fetch_vld_o, wrap_o, e.addr, e.vld, e.wrap);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seen[2048];
    int miss;
    int dup;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    n_vec++;
    if (fetch_addr_o !== 11'h3C0 || fetch_vld_o !== 1'b0 || wrap_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: addr=%h vld=%b wrap=%b, expected addr=3c0 vld=0 wrap=0",
               fetch_addr_o, fetch_vld_o, wrap_o);
    end
    rst_ni = 1'b1;

    // R2 / R3: fill with idle gaps and requests that must be ignored
    cycle(0, 0, '0, 0, '0, "R3 idle during fill");
    cycle(1, 1, 11'h123, 0, '0, "R2 fill xfer ignored");
    cycle(1, 0, '0, 1, 11'h456, "R2 fill tjmp ignored");
    cycle(0, 1, 11'h777, 0, '0, "R3 idle with request");
    cycle(1, 0, '0, 0, '0, "R2 fill");
    cycle(1, 1, 11'h0F0, 1, 11'h0F0, "R2 last fill step");

    // R4 R5 R6 R7: full sweep
    foreach (seen[i]) seen[i] = 0;
    for (int i = 0; i < 2048; i++) begin
      cycle(1, 0, '0, 0, '0, "R4 R5 R6 sweep");
      seen[last_addr] = seen[last_addr] + 1;
    end
    miss = 0;
    dup  = 0;
    foreach (seen[i]) begin
      if (seen[i] == 0) miss++;
      if (seen[i] > 1) dup++;
    end
    n_vec++;
    if (miss != 0 || dup != 0) begin
      n_bad++;
      $display("FAIL R7: missing=%0d repeated=%0d, expected missing=0 repeated=0", miss, dup);
    end
    cycle(0, 0, '0, 0, '0, "R7 back at start");
    n_vec++;
    if (last_addr !== 11'h3C0) begin
      n_bad++;
      $display("FAIL R7: addr after sweep=%h, expected 3c0", last_addr);
    end

    // R3: idle cycles after running
    cycle(0, 0, '0, 0, '0, "R3 idle");
    cycle(0, 1, 11'h3FF, 1, 11'h3FF, "R3 idle with requests");

    // R8 R10 R11: transfer with gap and competing requests
    cycle(1, 1, 11'h2B5, 0, '0, "R8 issue transfer");
    cycle(0, 0, '0, 0, '0, "R3 gap while pending");
    cycle(1, 1, 11'h001, 1, 11'h002, "R8 R10 load target");
    steps(5, "R11 continue after transfer");

    // R5 R6 R11: transfer to bank 31 position 100000, then carry wraps bank
    cycle(1, 1, 11'h7E0, 0, '0, "R8 issue transfer");
    cycle(1, 0, '0, 0, '0, "R8 load 7e0");
    steps(3, "R5 R6 R11 bank wrap after transfer");

    // R9 R10: table jump with ignored transfer in between
    cycle(1, 0, '0, 1, 11'h4C1, "R9 issue table jump");
    cycle(1, 1, 11'h111, 0, '0, "R9 R10 first in-between");
    cycle(0, 0, '0, 1, 11'h222, "R3 gap while pending");
    cycle(1, 0, '0, 1, 11'h333, "R9 R10 second in-between");
    cycle(1, 0, '0, 0, '0, "R9 load table target");
    steps(3, "R11 continue after table jump");

    // R10: both requests, transfer wins
    cycle(1, 1, 11'h0AA, 1, 11'h655, "R10 both issued");
    cycle(1, 0, '0, 0, '0, "R10 transfer target wins");
    steps(2, "R11 continue");

    cycle(0, 0, '0, 0, '0, "R3 drain");
    wait (q.size() == 0);
    @(negedge clk_i);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule